// File: doc/BRIEF.md
# Edge-Latched Interrupt Cause Register

This block turns the live status lines of a serial controller into one interrupt request. Each status line has a cause bit. The cause bit latches when its line goes from low to high. A line that stays high does not latch again after software has cleared its cause. A mask register enables each cause onto the shared interrupt output. Masking changes only the output and never stops a cause from latching.

Software uses a simple register port. One write port selects either the cause register, where a 1 clears that bit, or the mask register, which is written whole. A combinational read port returns the cause register, the mask register or the live status lines. All three use the same bit positions. Enabling a mask bit while its line is already high raises nothing, because only a transition is recorded. For that reason the driver checks the live status before it waits for an interrupt.

Top module: `irq_edge_cause`

## Requirements
- R1: A low-to-high change on `live_status[i]`, sampled at a clock edge, sets cause bit i at that same edge. The new value is visible on the read port and on `irq_out` after that edge.
- R2: A status line that stays high sets its cause only once. Once software has cleared the cause, it stays clear until the line falls and rises again.
- R3: A write with `wr_sel`=0 clears every cause bit whose `wr_data` bit is 1 and leaves the others unchanged. Writing all ones clears every cause.
- R4: When a rising edge and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R5: Cause bits latch whatever the mask holds. A write with `wr_sel`=1 loads the whole mask and does not change the cause bits. Without such a write the mask holds its value.
- R6: `irq_out` is 1 exactly when at least one cause bit is set together with its mask bit, and it follows the registers with no further delay.
- R7: Writing 0 to the mask forces `irq_out` low. Unmasking a cause whose line is already high, but whose cause bit is clear, does not raise `irq_out`.
- R8: Reset clears the cause and mask registers. The edge history resets to all ones, so a line that is already high when reset ends is not counted as a rise.
- R9: Read port: `rd_sel`=0 returns the cause register, 1 the mask, 2 the live status, and 3 returns zero. Bit i always refers to status line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_status | input | W | Live status lines from the controller |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 cause (write 1 to clear), 1 mask |
| wr_data | input | W | Write data |
| rd_sel | input | 2 | Read selector |
| rd_data | output | W | Read data |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench unmasks a cause whose line is still high after the cause was cleared. A design that latches on level would raise the interrupt there, and one that re-latches a held line would show the cause again after the clear. It applies a rising edge and a clear to the same bit in the same cycle; a design that gives priority to the clear would lose that event. It also holds a line high through reset and latches a change on the top bit. A reset history of zeros would create a cause that never happened, and an off-by-one in the bit positions would misreport the top bit. Masking everything while causes are pending checks that the cause bits survive even though the interrupt output drops.

// File: rtl/irq_edge_cause.sv
module irq_edge_cause #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_status,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         irq_out
);
  localparam logic [1:0] RD_CAUSE = 2'd0;
  localparam logic [1:0] RD_MASK  = 2'd1;
  localparam logic [1:0] RD_LIVE  = 2'd2;

  logic [W-1:0] prev_q, cause_q, mask_q;

  wire [W-1:0] rise = live_status & ~prev_q;
  wire [W-1:0] clr  = (wr_en && !wr_sel) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '1;
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      prev_q  <= live_status;
      cause_q <= (cause_q & ~clr) | rise;
      if (wr_en && wr_sel) mask_q <= wr_data;
    end
  end

  assign irq_out = |(cause_q & mask_q);

  always_comb begin
    case (rd_sel)
      RD_CAUSE: rd_data = cause_q;
      RD_MASK:  rd_data = mask_q;
      RD_LIVE:  rd_data = live_status;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_edge_cause_chk.sv
module irq_edge_cause_chk #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] live_status,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cause_q,
  input logic [W-1:0] mask_q,
  input logic         irq_out
);
  logic [W-1:0] hist;
  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '1;
    else        hist <= live_status;
  end
  wire [W-1:0] up = live_status & ~hist;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assert_rise_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      up[i] |=> cause_q[i]);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cause_q[i] && !up[i]) |=> !cause_q[i]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && wr_data[i] && !up[i]) |=> !cause_q[i]);
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (up[i] && wr_en && !wr_sel && wr_data[i]) |=> cause_q[i]);
  end

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> $stable(mask_q));
  assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data == '0) |=> !irq_out);
endmodule

bind irq_edge_cause irq_edge_cause_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .live_status(live_status), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .cause_q(cause_q), .mask_q(mask_q),
  .irq_out(irq_out)
);

// File: tb/sim_irq_edge_cause.sv
module sim_irq_edge_cause;
  localparam int W = 13;
  localparam time TCLK = 10ns;
  localparam logic [W-1:0] ONES = '1;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, irq_out;
  logic [W-1:0] live_status = '0, wr_data = '0, rd_data;
  logic [1:0] rd_sel = 2'd0;
  int n_chk = 0, n_bad = 0;

  logic [W-1:0] m_prev, m_cause, m_mask;
  logic [W-1:0] q_cause[$];
  logic         q_irq[$];
  string        q_req[$];

  always #(TCLK/2) clk = ~clk;

  irq_edge_cause #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .live_status(live_status), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_out(irq_out)
  );

  always @(negedge clk) begin
    if (q_cause.size() > 0) begin
      logic [W-1:0] ec; logic ei; string rq;
      ec = q_cause.pop_front(); ei = q_irq.pop_front(); rq = q_req.pop_front();
      n_chk++;
      if (rd_data !== ec || irq_out !== ei) begin
        n_bad++;
        $display("FAIL %s: cause=%h irq=%b, expected cause=%h irq=%b", rq, rd_data, irq_out, ec, ei);
      end
    end
  end

  task automatic cyc(input logic [W-1:0] st, input logic we, input logic ws,
                     input logic [W-1:0] wd, input string rq);
    @(negedge clk);
    live_status = st; wr_en = we; wr_sel = ws; wr_data = wd;
    @(posedge clk);
    m_cause = (m_cause & ~((we && !ws) ? wd : '0)) | (st & ~m_prev);
    m_prev = st;
    if (we && ws) m_mask = wd;
    q_cause.push_back(m_cause);
    q_irq.push_back(|(m_cause & m_mask));
    q_req.push_back(rq);
  endtask

  task automatic idle(input logic [W-1:0] st, input string rq);
    cyc(st, 1'b0, 1'b0, '0, rq);
  endtask

  task automatic readchk(input logic [1:0] sel, input logic [W-1:0] exp, input string rq);
    wait (q_cause.size() == 0);
    @(negedge clk);
    wr_en = 0;
    #2 rd_sel = sel;
    #1 n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: read sel %0d got %h, expected %h", rq, sel, rd_data, exp);
    end
    rd_sel = 2'd0;
  endtask

  initial begin
    repeat (400) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_prev = ONES; m_cause = '0; m_mask = '0;
    live_status = 13'h0001;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R8: line high through reset is no rise
    idle(13'h0001, "R8 reset history");
    readchk(2'd1, '0, "R8 mask reset");
    idle(13'h0000, "R8 line falls");
    // R1/R5: rise latches with mask zero, irq stays low
    idle(13'h0008, "R1 R5 rise bit3 masked");
    idle(13'h0008, "R2 held high");
    // R3: clear bit3 while still high, R2 no re-latch
    cyc(13'h0008, 1, 0, 13'h0008, "R3 clear bit3");
    idle(13'h0008, "R2 held after clear");
    // R7: unmask while line already high -> no irq
    cyc(13'h0008, 1, 1, 13'h0008, "R7 unmask high line");
    idle(13'h0008, "R7 still no irq");
    // R1/R6: fresh edge with mask set raises irq
    idle(13'h0000, "R1 fall");
    idle(13'h0008, "R6 rise unmasked");
    // R4: rise and clear same cycle
    cyc(13'h0028, 1, 0, 13'h0020, "R4 set wins");
    // R3: zero bits untouched
    cyc(13'h0028, 1, 0, 13'h0000, "R3 zero write no effect");
    // R9: top bit and live readback
    idle(13'h1028, "R9 top bit rise");
    readchk(2'd2, 13'h1028, "R9 live read");
    readchk(2'd0, 13'h1028, "R9 cause read");
    readchk(2'd3, '0, "R9 unused select");
    // R5: mask write leaves causes
    cyc(13'h1028, 1, 1, 13'h1000, "R5 mask write keeps causes");
    // R7: mask to zero drops irq, causes kept
    cyc(13'h1028, 1, 1, 13'h0000, "R7 mask zero");
    // R3: all ones clears all
    cyc(13'h0000, 1, 0, ONES, "R3 clear all");
    // multi-bit pattern
    cyc(13'h0A55, 1, 1, ONES, "R1 R6 pattern rise");
    idle(13'h05AA, "R1 pattern swap");
    cyc(13'h05AA, 1, 0, 13'h0F0F, "R3 partial clear");
    readchk(2'd1, ONES, "R5 mask readback");
    wait (q_cause.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule